// File: doc/BRIEF.md
# Private/Shared Memory Request Steering

This block sits between a core's load/store unit and two first-level caches: a private cache owned by the core, and a shared cache whose banks are spread one per tile. Each request carries a class tag that is already known at issue. Private and read-only shared requests go to the private cache. Modifiable shared requests go to the single bank that owns the block. That bank is picked from the address, so no block ever has a second copy and no invalidation or forwarding traffic is ever made.

When the owning bank is on the local tile, the request goes straight to the local bank port. When it is on another tile, the block builds an 8-byte control message. Store data travels in a separate word beside that message. The block then waits for a 16-byte response, made of an 8-byte control part followed by the 8-byte word. Each remote request holds a tag, and only a response whose tag and destination match an outstanding request reaches the core.

Control message layout (64 bits), used for requests and for the control half of responses: [31:0] address, [35:32] sender tile, [39:36] receiver tile, [43:40] tag (zero-extended), [44] store flag, [63:45] zero. In a response the control part sits in bits [127:64] and the word in bits [63:0].

Top module: `shared_steer`

## Requirements
- R1: A valid request of class 00 (private) or 01 (read-only shared) appears in the same cycle on the private port, with its address, write flag and data unchanged, and appears on no other port.
- R2: A request whose class has bit 1 set (modifiable shared) has home bank = address bits [9:6]. When the home bank equals `tile_id`, it appears only on the local bank port, in the same cycle.
- R3: A modifiable shared request with a remote home bank raises `net_req_valid` in the same cycle, with `net_req_dest` set to the home bank and `net_req_ctrl` built in the stated layout (sender = `tile_id`, receiver = home bank).
- R4: A remote store carries its write data on `net_req_wdata`. A remote load drives `net_req_wdata` to zero.
- R5: A response whose receiver field equals `tile_id` and whose tag is outstanding produces `core_rsp_valid` one clock later, with that tag and the low 64 bits as data. The tag is then free again.
- R6: When the outstanding request for the matched tag was a store, the core response has `core_rsp_ack` = 1 and zero data.
- R7: A response whose tag is not outstanding, or whose receiver field is another tile, is ignored: no core response, and an outstanding tag stays outstanding.
- R8: A remote request whose tag is still outstanding holds `req_ready` low and does not raise `net_req_valid`. Any other request has `req_ready` high.
- R9: At most one of the three request ports is valid in a cycle, and none is valid while `req_valid` is low.
- R10: After reset no tag is outstanding and `core_rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tile_id | input | 4 | Index of this tile |
| req_valid | input | 1 | Core request present |
| req_class | input | 2 | 00 private, 01 read-only shared, 1x modifiable shared |
| req_write | input | 1 | Store when high |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 64 | Store data |
| req_tag | input | 2 | Tag for a remote request |
| req_ready | output | 1 | Request can be taken this cycle |
| priv_valid | output | 1 | Request to private cache |
| priv_write | output | 1 | Store flag to private cache |
| priv_addr | output | 32 | Address to private cache |
| priv_wdata | output | 64 | Store data to private cache |
| bank_valid | output | 1 | Request to local shared bank |
| bank_write | output | 1 | Store flag to local bank |
| bank_addr | output | 32 | Address to local bank |
| bank_wdata | output | 64 | Store data to local bank |
| net_req_valid | output | 1 | Remote request message valid |
| net_req_dest | output | 4 | Home bank of remote request |
| net_req_ctrl | output | 64 | 8-byte control message |
| net_req_wdata | output | 64 | Store data beside the message |
| net_rsp_valid | input | 1 | Response message present |
| net_rsp_msg | input | 128 | Control part [127:64], word [63:0] |
| core_rsp_valid | output | 1 | Matched remote response to core |
| core_rsp_tag | output | 2 | Tag of that response |
| core_rsp_ack | output | 1 | Store acknowledgement, no data |
| core_rsp_data | output | 64 | Loaded word |

## Verification
The assertions assume that `tile_id` is constant after reset, and that the network gives back at most one response for each remote request. They also assume that the class tag is valid whenever `req_valid` is high. The bench holds `tile_id` at 5 from time zero. It sends each response only for a tag it knows is outstanding, except in the deliberate unmatched cases. It changes inputs only on the falling clock edge.

// File: rtl/shared_steer.sv
module shared_steer #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int NUM_BANKS = 16,
  parameter int BLK_OFF   = 6,
  parameter int TAG_W     = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(NUM_BANKS)-1:0] tile_id,
  input  logic                     req_valid,
  input  logic [1:0]               req_class,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [TAG_W-1:0]         req_tag,
  output logic                     req_ready,
  output logic                     priv_valid,
  output logic                     priv_write,
  output logic [ADDR_W-1:0]        priv_addr,
  output logic [DATA_W-1:0]        priv_wdata,
  output logic                     bank_valid,
  output logic                     bank_write,
  output logic [ADDR_W-1:0]        bank_addr,
  output logic [DATA_W-1:0]        bank_wdata,
  output logic                     net_req_valid,
  output logic [$clog2(NUM_BANKS)-1:0] net_req_dest,
  output logic [63:0]              net_req_ctrl,
  output logic [DATA_W-1:0]        net_req_wdata,
  input  logic                     net_rsp_valid,
  input  logic [64+DATA_W-1:0]     net_rsp_msg,
  output logic                     core_rsp_valid,
  output logic [TAG_W-1:0]         core_rsp_tag,
  output logic                     core_rsp_ack,
  output logic [DATA_W-1:0]        core_rsp_data
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int NTAG   = 1 << TAG_W;

  logic [NTAG-1:0] busy, wr_flag;

  wire              is_shared = req_class[1];
  wire [BANK_W-1:0] home      = req_addr[BLK_OFF +: BANK_W];
  wire              go_local  = is_shared && (home == tile_id);
  wire              go_remote = is_shared && !go_local;
  wire              tag_busy  = busy[req_tag];

  assign req_ready     = !(go_remote && tag_busy);
  assign priv_valid    = req_valid && !is_shared;
  assign priv_write    = req_write;
  assign priv_addr     = req_addr;
  assign priv_wdata    = req_wdata;
  assign bank_valid    = req_valid && go_local;
  assign bank_write    = req_write;
  assign bank_addr     = req_addr;
  assign bank_wdata    = req_wdata;
  assign net_req_valid = req_valid && go_remote && !tag_busy;
  assign net_req_dest  = home;
  assign net_req_wdata = req_write ? req_wdata : '0;

  always_comb begin
    net_req_ctrl        = '0;
    net_req_ctrl[31:0]  = 32'(req_addr);
    net_req_ctrl[35:32] = 4'(tile_id);
    net_req_ctrl[39:36] = 4'(home);
    net_req_ctrl[43:40] = 4'(req_tag);
    net_req_ctrl[44]    = req_write;
  end

  wire [63:0]       rsp_ctrl = net_rsp_msg[64 +: 64];
  wire [DATA_W-1:0] rsp_word = net_rsp_msg[DATA_W-1:0];
  wire [TAG_W-1:0]  rsp_tag  = rsp_ctrl[40 +: TAG_W];
  wire [BANK_W-1:0] rsp_dst  = rsp_ctrl[36 +: BANK_W];
  wire              rsp_hit  = net_rsp_valid && (rsp_dst == tile_id) && busy[rsp_tag];
  wire              unused_rsp_bits = ^{rsp_ctrl[63:44], rsp_ctrl[35:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy           <= '0;
      wr_flag        <= '0;
      core_rsp_valid <= 1'b0;
      core_rsp_tag   <= '0;
      core_rsp_ack   <= 1'b0;
      core_rsp_data  <= '0;
    end else begin
      if (net_req_valid) begin
        busy[req_tag]    <= 1'b1;
        wr_flag[req_tag] <= req_write;
      end
      if (rsp_hit) busy[rsp_tag] <= 1'b0;
      core_rsp_valid <= rsp_hit;
      if (rsp_hit) begin
        core_rsp_tag  <= rsp_tag;
        core_rsp_ack  <= wr_flag[rsp_tag];
        core_rsp_data <= wr_flag[rsp_tag] ? '0 : rsp_word;
      end
    end
  end
endmodule

// File: rtl/shared_steer_chk.sv
module shared_steer_chk #(
  parameter int BANK_W = 4,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BANK_W-1:0] tile_id,
  input logic              req_valid,
  input logic [1:0]        req_class,
  input logic              req_write,
  input logic              req_ready,
  input logic              priv_valid,
  input logic              bank_valid,
  input logic              net_req_valid,
  input logic [BANK_W-1:0] net_req_dest,
  input logic [DATA_W-1:0] net_req_wdata,
  input logic              net_rsp_valid,
  input logic              core_rsp_valid,
  input logic              core_rsp_ack,
  input logic [DATA_W-1:0] core_rsp_data
);
  a_r9_one_route: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({priv_valid, bank_valid, net_req_valid}) && (req_valid || !(priv_valid || bank_valid || net_req_valid)));
  a_r1_priv_class: assert property (@(posedge clk) disable iff (!rst_n)
    priv_valid |-> !req_class[1]);
  a_r3_remote_dest: assert property (@(posedge clk) disable iff (!rst_n)
    net_req_valid |-> net_req_dest != tile_id);
  a_r4_load_nodata: assert property (@(posedge clk) disable iff (!rst_n)
    net_req_valid && !req_write |-> net_req_wdata == '0);
  a_r5_rsp_after_msg: assert property (@(posedge clk) disable iff (!rst_n)
    core_rsp_valid |-> $past(net_rsp_valid));
  a_r6_ack_nodata: assert property (@(posedge clk) disable iff (!rst_n)
    core_rsp_valid && core_rsp_ack |-> core_rsp_data == '0);
  a_r8_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !net_req_valid && req_class[1]);
endmodule

bind shared_steer shared_steer_chk #(.BANK_W($clog2(NUM_BANKS)), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tile_id(tile_id), .req_valid(req_valid),
  .req_class(req_class), .req_write(req_write), .req_ready(req_ready),
  .priv_valid(priv_valid), .bank_valid(bank_valid), .net_req_valid(net_req_valid),
  .net_req_dest(net_req_dest), .net_req_wdata(net_req_wdata),
  .net_rsp_valid(net_rsp_valid), .core_rsp_valid(core_rsp_valid),
  .core_rsp_ack(core_rsp_ack), .core_rsp_data(core_rsp_data));

// File: tb/sim_shared_steer.sv
module sim_shared_steer;
  logic clk = 0, rst_n = 0;
  logic [3:0] tile_id = 4'd5;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_class = 0;
  logic [31:0] req_addr = 0;
  logic [63:0] req_wdata = 0;
  logic [1:0] req_tag = 0;
  logic req_ready, priv_valid, priv_write, bank_valid, bank_write, net_req_valid;
  logic [31:0] priv_addr, bank_addr;
  logic [63:0] priv_wdata, bank_wdata, net_req_ctrl, net_req_wdata;
  logic [3:0] net_req_dest;
  logic net_rsp_valid = 0;
  logic [127:0] net_rsp_msg = 0;
  logic core_rsp_valid, core_rsp_ack;
  logic [1:0] core_rsp_tag;
  logic [63:0] core_rsp_data;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  shared_steer u0 (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ctl(input logic [31:0] a, input logic [3:0] s,
      input logic [3:0] d, input logic [3:0] t, input logic w);
    return {19'd0, w, t, d, s, a};
  endfunction

  task automatic drive(input logic [1:0] c, input logic w, input logic [31:0] a,
      input logic [63:0] d, input logic [1:0] t);
    @(negedge clk);
    req_valid = 1; req_class = c; req_write = w; req_addr = a; req_wdata = d; req_tag = t;
    #1;
  endtask

  task automatic idle();
    @(negedge clk); req_valid = 0; #1;
  endtask

  task automatic respond(input logic [3:0] dst, input logic [1:0] t, input logic w,
      input logic [63:0] word);
    @(negedge clk);
    net_rsp_valid = 1; net_rsp_msg = {ctl(32'h0, 4'd9, dst, 4'(t), w), word};
    @(negedge clk);
    net_rsp_valid = 0; #1;
  endtask

  task automatic t_reset();
    chk("R10 core_rsp_valid", core_rsp_valid, 0);
    chk("R9 no port valid when idle", {priv_valid, bank_valid, net_req_valid}, 0);
    chk("R10 ready after reset", req_ready, 1);
  endtask

  task automatic t_private();
    drive(2'b00, 1, 32'h0000_A248, 64'h1111, 0);
    chk("R1 private route", {priv_valid, bank_valid, net_req_valid}, 3'b100);
    chk("R1 private fields", {priv_write, priv_addr, priv_wdata}, {1'b1, 32'h0000_A248, 64'h1111});
    drive(2'b01, 0, 32'h0000_0140, 64'h0, 0);
    chk("R1 read-only shared to private", {priv_valid, bank_valid, net_req_valid}, 3'b100);
    idle();
  endtask

  task automatic t_local();
    drive(2'b10, 1, 32'h1234_0140, 64'hBEEF, 0);
    chk("R2 local home route", {priv_valid, bank_valid, net_req_valid}, 3'b010);
    chk("R2 local fields", {bank_write, bank_addr, bank_wdata}, {1'b1, 32'h1234_0140, 64'hBEEF});
    drive(2'b11, 0, 32'h0000_0140, 64'h0, 0);
    chk("R2 class 11 local", bank_valid, 1);
    idle();
  endtask

  task automatic t_remote();
    drive(2'b10, 0, 32'h0000_A248, 64'h5555, 2'd1);
    chk("R3 remote route", {priv_valid, bank_valid, net_req_valid, req_ready}, 4'b0011);
    chk("R3 dest", net_req_dest, 4'd9);
    chk("R3 ctrl", net_req_ctrl, ctl(32'h0000_A248, 4'd5, 4'd9, 4'd1, 0));
    chk("R4 load has zero data", net_req_wdata, 0);
    @(posedge clk);
    drive(2'b10, 0, 32'h0000_A248, 64'h0, 2'd1);
    chk("R8 busy tag stalls", {req_ready, net_req_valid}, 2'b00);
    drive(2'b10, 1, 32'h0000_00C0, 64'hCAFE, 2'd2);
    chk("R4 store data carried", {net_req_valid, net_req_wdata}, {1'b1, 64'hCAFE});
    chk("R3 store ctrl", net_req_ctrl, ctl(32'h0000_00C0, 4'd5, 4'd3, 4'd2, 1));
    @(posedge clk);
    idle();
  endtask

  task automatic t_responses();
    respond(4'd5, 2'd1, 0, 64'hDEAD_BEEF_0123_4567);
    chk("R5 matched response", {core_rsp_valid, core_rsp_tag, core_rsp_ack}, {1'b1, 2'd1, 1'b0});
    chk("R5 response data", core_rsp_data, 64'hDEAD_BEEF_0123_4567);
    @(negedge clk); #1;
    chk("R5 single pulse", core_rsp_valid, 0);
    drive(2'b10, 0, 32'h0000_A248, 64'h0, 2'd1);
    chk("R5 tag freed", {req_ready, net_req_valid}, 2'b11);
    @(posedge clk);
    idle();
    respond(4'd5, 2'd2, 1, 64'h7777);
    chk("R6 store ack", {core_rsp_valid, core_rsp_tag, core_rsp_ack}, {1'b1, 2'd2, 1'b1});
    chk("R6 ack data zero", core_rsp_data, 0);
  endtask

  task automatic t_unmatched();
    respond(4'd5, 2'd3, 0, 64'h9999);
    chk("R7 unknown tag ignored", core_rsp_valid, 0);
    respond(4'd6, 2'd1, 0, 64'h9999);
    chk("R7 wrong receiver ignored", core_rsp_valid, 0);
    drive(2'b10, 0, 32'h0000_A248, 64'h0, 2'd1);
    chk("R7 tag still outstanding", req_ready, 0);
    idle();
    respond(4'd5, 2'd1, 0, 64'h4242);
    chk("R7 later match accepted", {core_rsp_valid, core_rsp_data}, {1'b1, 64'h4242});
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #9 rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_private();
    t_local();
    t_remote();
    t_responses();
    t_unmatched();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule